// File: doc/BRIEF.md
# NOR Buffered-Program Engine

This engine writes a burst of halfwords into a NOR flash through the device's buffered-program command rather than issuing a full program command for every word. A client pulses `start` with a start address and a word count, then streams the data words on a valid/ready input. The engine drives a simple write-only bus master port (valid/ready per write cycle). This is the same port a general command sequencer would use, so either block can own the flash bus through an external arbiter.

Once a request is accepted, the engine issues the following writes in order:
- the two unlock writes;
- the buffer-load command at the start address;
- the count-minus-one word at the start address;
- every data word at consecutive halfword addresses;
- finally the program-confirm command, aimed at the address of the last word loaded.

The engine raises `done` for one cycle after the confirm write is accepted. It does not poll the device for completion and does not check address alignment. A request with a count of zero, or with a count above the buffer limit `MAX_WORDS`, is refused with a one-cycle `err` pulse and no bus traffic.

Top module: `nor_wb_engine`

## Requirements
- R1: After reset, `busy`, `bus_valid`, `din_ready`, `done` and `err` are all low.
- R2: An accepted request first issues two writes: data 0x00AA at address 0x555, then data 0x0055 at address 0x2AA.
- R3: The third write carries data 0x0025 to the start address.
- R4: The fourth write carries word count minus one, zero-extended, to the start address.
- R5: Data word i (counting from 0) is written to start address + i, in arrival order, for i from 0 to count-1.
- R6: The last write carries data 0x0029 to start address + count - 1.
- R7: `done` is high for exactly the one cycle after the confirm write is accepted, and `busy` is low in that cycle.
- R8: A `start` with count 0 or count above `MAX_WORDS` gives `err` high in the next cycle for one cycle, leaves `busy` low and issues no bus write. A count equal to `MAX_WORDS` is accepted.
- R9: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_addr` and `bus_wdata` hold in the next cycle. While `din_valid` is low during the data phase, no data write is issued, and the sequence resumes unchanged when data arrives.
- R10: A `start` pulse while `busy` is high is ignored: the running sequence continues with its original address and count, and no new sequence follows it.
- R11: A data word is consumed (`din_valid` and `din_ready` both high) only in a cycle where the bus accepts a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only while idle |
| start_addr | input | AW | Halfword address of the first data word |
| word_cnt | input | CW | Number of data words, 1 to MAX_WORDS |
| din_valid | input | 1 | Data word present |
| din_data | input | DW | Data word |
| din_ready | output | 1 | Data word taken at this edge when valid |
| bus_valid | output | 1 | Write cycle requested |
| bus_addr | output | AW | Write cycle halfword address |
| bus_wdata | output | DW | Write cycle data |
| bus_ready | input | 1 | Write cycle accepted at this edge when valid |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse after the confirm write |
| err | output | 1 | One-cycle pulse for a refused count |

## Verification
The bench tries the sequence with several input patterns:
- a free-flowing bus and source with a mid-range count;
- a single word, where the confirm address equals the start address;
- the full buffer limit with a stuttering data source, which separates data-phase gaps from bus stalls;
- an irregular bus and an irregular source combined with a stray `start`, which shows whether a busy request is ignored.

Counts of zero and one above the limit are tried separately. These show whether the refusal happens before any bus cycle and whether the limit itself is inclusive.

// File: rtl/nor_wb_pkg.sv
package nor_wb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNLK1,
    ST_UNLK2,
    ST_LOAD,
    ST_COUNT,
    ST_DATA,
    ST_CONFIRM
  } wb_state_e;

  // Fixed command addresses and codes of the buffered-program protocol
  localparam logic [11:0] UNLK1_ADDR  = 12'h555;
  localparam logic [11:0] UNLK2_ADDR  = 12'h2AA;
  localparam logic [7:0]  UNLK1_CODE  = 8'hAA;
  localparam logic [7:0]  UNLK2_CODE  = 8'h55;
  localparam logic [7:0]  LOAD_CODE   = 8'h25;
  localparam logic [7:0]  CONFIRM_CODE = 8'h29;

endpackage

// File: rtl/nor_wb_rst_sync.sv
module nor_wb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/nor_wb_seq.sv
module nor_wb_seq
  import nor_wb_pkg::*;
#(
  parameter int AW        = 24,
  parameter int MAX_WORDS = 32,
  localparam int CW       = $clog2(MAX_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] word_cnt,
  input  logic          xfer,
  output wb_state_e     state,
  output logic [AW-1:0] base,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] idx,
  output logic          done,
  output logic          err
);
  wb_state_e     state_q, state_d;
  logic [AW-1:0] base_q;
  logic [CW-1:0] cnt_q, idx_q, idx_d;
  logic          done_q, done_d, err_q, err_d;
  logic          load_en, idx_en, bad_cnt;

  assign bad_cnt = (word_cnt == '0) || (word_cnt > CW'(MAX_WORDS));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    load_en = 1'b0;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (bad_cnt) begin
            err_d = 1'b1;
          end else begin
            load_en = 1'b1;
            idx_en  = 1'b1;
            idx_d   = '0;
            state_d = ST_UNLK1;
          end
        end
      end
      ST_UNLK1: if (xfer) state_d = ST_UNLK2;
      ST_UNLK2: if (xfer) state_d = ST_LOAD;
      ST_LOAD:  if (xfer) state_d = ST_COUNT;
      ST_COUNT: if (xfer) state_d = ST_DATA;
      ST_DATA: begin
        if (xfer) begin
          if (idx_q == cnt_q - CW'(1)) begin
            state_d = ST_CONFIRM;
          end else begin
            idx_en = 1'b1;
            idx_d  = idx_q + CW'(1);
          end
        end
      end
      ST_CONFIRM: begin
        if (xfer) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_en) begin
      base_q <= start_addr;
      cnt_q  <= word_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign state = state_q;
  assign base  = base_q;
  assign cnt   = cnt_q;
  assign idx   = idx_q;
  assign done  = done_q;
  assign err   = err_q;
endmodule

// File: rtl/nor_wb_bus_mux.sv
module nor_wb_bus_mux
  import nor_wb_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int CW = 6
) (
  input  wb_state_e     state,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] idx,
  input  logic          din_valid,
  input  logic [DW-1:0] din_data,
  output logic          bus_valid,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata
);
  always_comb begin
    bus_valid = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    unique case (state)
      ST_UNLK1: begin
        bus_valid = 1'b1;
        bus_addr  = AW'(UNLK1_ADDR);
        bus_wdata = DW'(UNLK1_CODE);
      end
      ST_UNLK2: begin
        bus_valid = 1'b1;
        bus_addr  = AW'(UNLK2_ADDR);
        bus_wdata = DW'(UNLK2_CODE);
      end
      ST_LOAD: begin
        bus_valid = 1'b1;
        bus_addr  = base;
        bus_wdata = DW'(LOAD_CODE);
      end
      ST_COUNT: begin
        bus_valid = 1'b1;
        bus_addr  = base;
        bus_wdata = DW'(cnt - CW'(1));
      end
      ST_DATA: begin
        bus_valid = din_valid;
        bus_addr  = base + AW'(idx);
        bus_wdata = din_data;
      end
      ST_CONFIRM: begin
        bus_valid = 1'b1;
        bus_addr  = base + AW'(cnt) - AW'(1);
        bus_wdata = DW'(CONFIRM_CODE);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/nor_wb_engine.sv
module nor_wb_engine
  import nor_wb_pkg::*;
#(
  parameter int AW        = 24,
  parameter int DW        = 16,
  parameter int MAX_WORDS = 32,
  localparam int CW       = $clog2(MAX_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] word_cnt,
  input  logic          din_valid,
  input  logic [DW-1:0] din_data,
  output logic          din_ready,
  output logic          bus_valid,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready,
  output logic          busy,
  output logic          done,
  output logic          err
);
  logic          rst_sync_n;
  wb_state_e     state;
  logic [AW-1:0] base;
  logic [CW-1:0] cnt, idx;
  logic          xfer;

  nor_wb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  nor_wb_seq #(.AW(AW), .MAX_WORDS(MAX_WORDS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .start_addr (start_addr),
    .word_cnt   (word_cnt),
    .xfer       (xfer),
    .state      (state),
    .base       (base),
    .cnt        (cnt),
    .idx        (idx),
    .done       (done),
    .err        (err)
  );

  nor_wb_bus_mux #(.AW(AW), .DW(DW), .CW(CW)) u_mux (
    .state     (state),
    .base      (base),
    .cnt       (cnt),
    .idx       (idx),
    .din_valid (din_valid),
    .din_data  (din_data),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
  );

  assign xfer      = bus_valid && bus_ready;
  assign din_ready = (state == ST_DATA) && bus_ready;
  assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/nor_wb_engine_chk.sv
module nor_wb_engine_chk #(
  parameter int AW        = 24,
  parameter int DW        = 16,
  parameter int MAX_WORDS = 32,
  parameter int CW        = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [CW-1:0] word_cnt,
  input logic          din_valid,
  input logic          din_ready,
  input logic          bus_valid,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ready,
  input logic          busy,
  input logic          done,
  input logic          err
);
  // First cycle of a sequence is the first unlock write
  assert_unlock_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> bus_valid && bus_addr == AW'(12'h555) && bus_wdata == DW'(8'hAA));

  assert_done_after_confirm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(bus_valid && bus_ready && bus_wdata == DW'(8'h29)));

  assert_refuse_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (word_cnt == '0 || word_cnt > CW'(MAX_WORDS)))
      |=> err && !busy && !bus_valid);

  assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !bus_valid);

  assert_bus_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> bus_valid && $stable(bus_addr) && $stable(bus_wdata));

  assert_consume_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && din_ready) |-> bus_valid && bus_ready);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_valid && !din_ready);
endmodule

bind nor_wb_engine nor_wb_engine_chk #(
  .AW(AW), .DW(DW), .MAX_WORDS(MAX_WORDS), .CW(CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start     (start),
  .word_cnt  (word_cnt),
  .din_valid (din_valid),
  .din_ready (din_ready),
  .bus_valid (bus_valid),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_ready (bus_ready),
  .busy      (busy),
  .done      (done),
  .err       (err)
);

// File: tb/nor_wb_engine_tb.sv
module nor_wb_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int MAX_WORDS = 32;
  localparam int CW = $clog2(MAX_WORDS + 1);

  typedef struct packed {
    logic [23:0] addr;
    logic [7:0]  cnt;
    logic [7:0]  rdy;
    logic [7:0]  vld;
    logic        poke;
  } vec_t;

  localparam int NVEC = 4;
  localparam vec_t VECS [NVEC] = '{
    '{24'h000100, 8'd4,  8'hFF,        8'hFF,        1'b0},
    '{24'h001230, 8'd1,  8'b10110110,  8'hFF,        1'b0},
    '{24'h0040A0, 8'd32, 8'hFF,        8'b10010011,  1'b0},
    '{24'h00FFF0, 8'd7,  8'b01101101,  8'b01011101,  1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] start_addr;
  logic [CW-1:0] word_cnt;
  logic          din_valid;
  logic [DW-1:0] din_data;
  logic          din_ready;
  logic          bus_valid;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_ready;
  logic          busy, done, err;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_wb_engine #(.AW(AW), .DW(DW), .MAX_WORDS(MAX_WORDS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .word_cnt(word_cnt), .din_valid(din_valid), .din_data(din_data),
    .din_ready(din_ready), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .busy(busy),
    .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input int r, input int i);
    return DW'(16'hA000 + r * 16'h0100 + i * 16'h0013);
  endfunction

  // Expected k-th write of a sequence: {addr, data}
  function automatic logic [AW+DW-1:0] exp_write(input vec_t v, input int r, input int k);
    int n = int'(v.cnt);
    if (k == 0)          return {AW'(12'h555), DW'(8'hAA)};
    else if (k == 1)     return {AW'(12'h2AA), DW'(8'h55)};
    else if (k == 2)     return {v.addr, DW'(8'h25)};
    else if (k == 3)     return {v.addr, DW'(n - 1)};
    else if (k < 4 + n)  return {v.addr + AW'(k - 4), word_of(r, k - 4)};
    else                 return {v.addr + AW'(n - 1), DW'(8'h29)};
  endfunction

  function automatic string tag_of(input int k, input int n);
    if (k < 2)       return "R2";
    else if (k == 2) return "R3";
    else if (k == 3) return "R4";
    else if (k < 4 + n) return "R5";
    else             return "R6";
  endfunction

  task automatic run_vec(input vec_t v, input int r);
    int n = int'(v.cnt);
    int wr = 0;
    int di = 0;
    bit took = 0;
    bit seen_done = 0;
    @(negedge clk);
    start = 1'b1; start_addr = v.addr; word_cnt = CW'(n);
    din_valid = 1'b0; bus_ready = 1'b0;
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (v.poke && c == 5) begin
        start = 1'b1; start_addr = 24'h0ABCDE; word_cnt = CW'(2);
      end
      if (took) begin din_valid = 1'b0; took = 0; end
      if (!din_valid && di < n && v.vld[c % 8]) begin
        din_valid = 1'b1; din_data = word_of(r, di);
      end
      bus_ready = v.rdy[c % 8];
      #1;
      if (wr == n + 5) begin
        chk(done === 1'b1, "R7 done", done, 1);
        chk(busy === 1'b0, "R7 busy", busy, 0);
        seen_done = 1;
        break;
      end
      chk(done === 1'b0, "R7 early done", done, 0);
      if (din_valid && din_ready) begin
        chk(bus_valid && bus_ready, "R11", {bus_valid, bus_ready}, 2'b11);
        di++; took = 1;
      end
      if (bus_valid && bus_ready) begin
        chk({bus_addr, bus_wdata} === exp_write(v, r, wr), tag_of(wr, n),
            {bus_addr, bus_wdata}, exp_write(v, r, wr));
        wr++;
      end else if (!bus_valid && busy && wr >= 4 && wr < 4 + n) begin
        // data phase gap: no write may slip through without data (R9)
        chk(din_valid === 1'b0 || bus_ready === 1'b0, "R9 gap", din_valid, 0);
      end
    end
    chk(seen_done, "R7 completion", seen_done, 1);
    bus_ready = 1'b0; din_valid = 1'b0;
    // R10: a stray start during the run must not launch a second sequence
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      chk(!busy && !bus_valid && !done, "R10 no follow-on", {busy, bus_valid, done}, 0);
    end
  endtask

  task automatic bad_count(input int n);
    @(negedge clk);
    start = 1'b1; start_addr = 24'h000200; word_cnt = CW'(n); bus_ready = 1'b1;
    @(negedge clk); #1;
    chk(err === 1'b1, "R8 err", err, 1);
    chk(!busy && !bus_valid, "R8 idle", {busy, bus_valid}, 0);
    start = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      chk(!err && !busy && !bus_valid, "R8 quiet", {err, busy, bus_valid}, 0);
    end
    bus_ready = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; start_addr = '0; word_cnt = '0;
    din_valid = 1'b0; din_data = '0; bus_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !bus_valid && !din_ready && !done && !err, "R1 in reset",
        {busy, bus_valid, din_ready, done, err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(!busy && !bus_valid && !din_ready && !done && !err, "R1 after reset",
        {busy, bus_valid, din_ready, done, err}, 0);

    for (int r = 0; r < NVEC; r++) run_vec(VECS[r], r);

    bad_count(0);
    bad_count(MAX_WORDS + 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule